// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Late-Write Pipeline

This block is a synthesizable behavioural model of a synchronous burst SRAM. Reads and writes can be issued in any mix on every clock cycle, and the data bus never needs an idle turnaround cycle. Every input is sampled on the rising clock edge. Read data leaves through an output register. Write data trails its address by two cycles, so a write's data slot lines up with the slot a read's data would occupy.

The address and byte selects of a write travel through two command stages before the word array is written. A read that targets a word whose write is still in flight returns that pending data, merged lane by lane with the stored word. A combined advance/load strobe either loads a fresh address or steps a four-beat burst, in linear or interleaved order. A clock enable freezes the whole block.

The bidirectional data bus is split into `din`, `dout` and `dout_oe`. Surrounding logic or a pad wrapper drives the bus from `dout` whenever `dout_oe` is high.

Top module: `pipelined_sram`

## Requirements
- R1: A read loaded at enabled edge n presents its word on `dout` with `dout_oe` high right after enabled edge n+1. That is the second cycle after the address was presented.
- R2: While `clk_en` is low, no register changes: `dout` and `dout_oe` hold, and an edge with `clk_en` low is not counted by any pipeline delay.
- R3: Reads and writes may alternate on consecutive cycles with no idle cycles. Write data on `din` is sampled at the second enabled edge after the edge that took the write address.
- R4: `byte_sel` is active high, one bit per lane, and lane i occupies bits [9i+8:9i]. A write updates only the selected lanes and leaves the other lanes' stored bits unchanged.
- R5: A load cycle is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination issues a no-op that returns no data, and a write already in flight still completes.
- R6: `dout_oe` is high only in the data cycle of a read. It is low in write data cycles and after no-ops.
- R7: A read of a word whose write data arrives at the same edge that registers the read result returns the new data in the selected lanes and the stored data in the rest.
- R8: With `adv_load`=1, the burst started by the last load continues. The operation type comes from that load, and the chip enables and `wr_en` are ignored. The two low address bits take base+k mod 4 if `burst_interleave` was 0 at the load, or base XOR k if it was 1, for beat k=1,2,3. After a deselected load, advancing gives no-ops.
- R9: During reset and after its synchronous release, `dout_oe` is 0, `dout` is 0 and the pipeline holds no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock enable; low freezes all state |
| adv_load | input | 1 | 0 loads a new address, 1 advances the current burst |
| wr_en | input | 1 | 1 = write, 0 = read, sampled on load cycles |
| byte_sel | input | LANES | Per-lane write select, active high |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| burst_interleave | input | 1 | Burst order on load: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| din | input | LANES*9 | Write data, two cycles after the address |
| dout | output | LANES*9 | Registered read data |
| dout_oe | output | 1 | Drive enable for the read data cycle |

## Verification
Read data is due one enabled edge after the edge that took the read command, and write data is applied two enabled edges after its address. The bench advances one edge per row and samples a quarter period after each edge. In the stimulus table, each row's expected output therefore belongs to the command issued one row earlier, and each row's `din` feeds the write issued two rows earlier. The stall tests insert edges with `clk_en` low and check that these edges move neither the outputs nor the write data slot.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits of a burst beat: linear add or interleaved XOR.
  function automatic logic [BURST_W-1:0] beat_bits(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] step,
    input logic               ilv
  );
    return ilv ? (base ^ step) : (base + step);
  endfunction

endpackage

// File: rtl/psram_burst.sv
module psram_burst
  import psram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             adv,
  input  logic             sel,
  input  logic             wr,
  input  logic             ilv_in,
  input  logic [AW-1:0]    addr_in,
  input  logic [LANES-1:0] be_in,
  output op_e              cmd_op,
  output logic [AW-1:0]    cmd_addr,
  output logic [LANES-1:0] cmd_be
);

  logic [AW-1:0]      base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic               wr_q, wr_d;
  logic               act_q, act_d;
  logic               ilv_q, ilv_d;
  logic [BURST_W-1:0] step;

  assign step = cnt_q + 1'b1;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    act_d  = act_q;
    ilv_d  = ilv_q;
    if (!adv) begin
      base_d = addr_in;
      cnt_d  = '0;
      wr_d   = wr;
      act_d  = sel;
      ilv_d  = ilv_in;
    end else if (act_q) begin
      cnt_d = step;
    end
  end

  always_comb begin
    cmd_be = be_in;
    if (!adv) begin
      cmd_addr = addr_in;
      cmd_op   = sel ? (wr ? OP_WRITE : OP_READ) : OP_IDLE;
    end else begin
      cmd_addr = {base_q[AW-1:BURST_W], beat_bits(base_q[BURST_W-1:0], step, ilv_q)};
      cmd_op   = act_q ? (wr_q ? OP_WRITE : OP_READ) : OP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      act_q  <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (ce) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      act_q  <= act_d;
      ilv_q  <= ilv_d;
    end
  end

  // R8: an enabled advance of a live burst moves the beat counter by one
  a_r8_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv && act_q) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));

  // R8: advancing a dead burst issues nothing
  a_r8_dead_burst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !act_q) |-> (cmd_op == OP_IDLE));

endmodule

// File: rtl/psram_pipe.sv
module psram_pipe
  import psram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  op_e              in_op,
  input  logic [AW-1:0]    in_addr,
  input  logic [LANES-1:0] in_be,
  output op_e              s1_op,
  output logic [AW-1:0]    s1_addr,
  output op_e              s2_op,
  output logic [AW-1:0]    s2_addr,
  output logic [LANES-1:0] s2_be
);

  logic [LANES-1:0] s1_be;
  op_e              s1_op_d, s2_op_d;
  logic [AW-1:0]    s1_addr_d, s2_addr_d;
  logic [LANES-1:0] s1_be_d, s2_be_d;

  always_comb begin
    s1_op_d   = ce ? in_op   : s1_op;
    s1_addr_d = ce ? in_addr : s1_addr;
    s1_be_d   = ce ? in_be   : s1_be;
    s2_op_d   = ce ? s1_op   : s2_op;
    s2_addr_d = ce ? s1_addr : s2_addr;
    s2_be_d   = ce ? s1_be   : s2_be;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else begin
      s1_op   <= s1_op_d;
      s1_addr <= s1_addr_d;
      s1_be   <= s1_be_d;
      s2_op   <= s2_op_d;
      s2_addr <= s2_addr_d;
      s2_be   <= s2_be_d;
    end
  end

  // R5: a write in stage one always reaches the data stage, whatever follows it
  a_r5_write_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && s1_op == OP_WRITE) |=> (s2_op == OP_WRITE));

  // R2: a frozen edge leaves both stages untouched
  a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce) |=> ($stable(s1_op) && $stable(s2_op) && $stable(s2_addr)));

endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES-1:0]    wbe,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[g]) begin
        lane_mem[waddr] <= wdata[g*LW +: LW];
      end
    end

    assign rdata[g*LW +: LW] = lane_mem[raddr];
  end

endmodule

// File: rtl/pipelined_sram.sv
module pipelined_sram
  import psram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en,
  input  logic                adv_load,
  input  logic                wr_en,
  input  logic [LANES-1:0]    byte_sel,
  input  logic                cs1_n,
  input  logic                cs2,
  input  logic                cs3_n,
  input  logic                burst_interleave,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] din,
  output logic [LANES*LW-1:0] dout,
  output logic                dout_oe
);

  localparam int DW = LANES * LW;

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic             chip_sel;
  op_e              cmd_op, s1_op, s2_op;
  logic [AW-1:0]    cmd_addr, s1_addr, s2_addr;
  logic [LANES-1:0] cmd_be, s2_be;
  logic [DW-1:0]    arr_rdata, merged;
  logic             arr_we;
  logic [DW-1:0]    dout_d;
  logic             oe_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign chip_sel = !cs1_n && cs2 && !cs3_n;

  psram_burst #(.AW(AW), .LANES(LANES)) i_burst (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ce       (clk_en),
    .adv      (adv_load),
    .sel      (chip_sel),
    .wr       (wr_en),
    .ilv_in   (burst_interleave),
    .addr_in  (addr),
    .be_in    (byte_sel),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .cmd_be   (cmd_be)
  );

  psram_pipe #(.AW(AW), .LANES(LANES)) i_pipe (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ce      (clk_en),
    .in_op   (cmd_op),
    .in_addr (cmd_addr),
    .in_be   (cmd_be),
    .s1_op   (s1_op),
    .s1_addr (s1_addr),
    .s2_op   (s2_op),
    .s2_addr (s2_addr),
    .s2_be   (s2_be)
  );

  assign arr_we = clk_en && (s2_op == OP_WRITE);

  psram_array #(.AW(AW), .LANES(LANES), .LW(LW)) i_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (s2_addr),
    .wbe   (s2_be),
    .wdata (din),
    .raddr (s1_addr),
    .rdata (arr_rdata)
  );

  // coherency: the write landing this edge overrides its selected lanes
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    logic hit;
    assign hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr) && s2_be[g];
    assign merged[g*LW +: LW] = hit ? din[g*LW +: LW] : arr_rdata[g*LW +: LW];
  end

  always_comb begin
    oe_d   = (s1_op == OP_READ);
    dout_d = oe_d ? merged : dout;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else if (clk_en) begin
      dout    <= dout_d;
      dout_oe <= oe_d;
    end
  end

  // R2: outputs frozen while the clock enable is low
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!clk_en) |=> ($stable(dout) && $stable(dout_oe)));

  // R1: a read in stage one drives the bus after the next enabled edge
  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_i_n)
    (clk_en && s1_op == OP_READ) |=> dout_oe);

  // R6: write data cycles never drive the bus
  a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    (clk_en && s1_op == OP_WRITE) |=> !dout_oe);

  // R5: a deselected load enters the pipeline as a no-op
  a_r5_deselect_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (clk_en && !adv_load && !chip_sel) |=> (s1_op == OP_IDLE));

endmodule

// File: tb/test_pipelined_sram.sv
module test_pipelined_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LANES = 4;
  localparam int DW = 36;
  localparam int NROWS = 23;

  typedef struct packed {
    logic          adv;
    logic          sel;
    logic          wr;
    logic [3:0]    be;
    logic [7:0]    a;
    logic          mode;
    logic [DW-1:0] d;
    logic          eoe;
    logic [DW-1:0] edo;
  } vec_t;

  localparam logic [DW-1:0] VA = 36'h1A1A1A1A1;
  localparam logic [DW-1:0] VB = 36'h2B2B2B2B2;
  localparam logic [DW-1:0] VC = 36'h3C3C3C3C3;
  localparam logic [DW-1:0] VD = 36'h4D4D4D4D4;
  localparam logic [DW-1:0] E0 = 36'h500000001;
  localparam logic [DW-1:0] E1 = 36'h600000002;
  localparam logic [DW-1:0] E2 = 36'h700000003;
  localparam logic [DW-1:0] E3 = 36'h800000004;
  // R4: lanes 0 and 2 from VD, lanes 1 and 3 kept from VB
  localparam logic [DW-1:0] VM = {VB[35:27], VD[26:18], VB[17:9], VD[8:0]};
  localparam logic [DW-1:0] Z = '0;

  // din of row i serves the write of row i-2; expected output of row i belongs to row i-1
  localparam vec_t TBL [NROWS] = '{
    '{1'b0,1'b1,1'b1,4'hF,8'h10,1'b0,Z ,1'b0,Z },
    '{1'b0,1'b1,1'b1,4'hF,8'h11,1'b0,Z ,1'b0,Z },
    '{1'b0,1'b1,1'b0,4'hF,8'h10,1'b0,VA,1'b0,Z },
    '{1'b0,1'b1,1'b1,4'hF,8'h12,1'b0,VB,1'b1,VA},
    '{1'b0,1'b1,1'b0,4'hF,8'h12,1'b0,Z ,1'b0,Z },
    '{1'b0,1'b1,1'b0,4'hF,8'h11,1'b0,VC,1'b1,VC},
    '{1'b0,1'b1,1'b1,4'h5,8'h11,1'b0,Z ,1'b1,VB},
    '{1'b0,1'b1,1'b0,4'hF,8'h11,1'b0,Z ,1'b0,Z },
    '{1'b0,1'b0,1'b0,4'hF,8'h00,1'b0,VD,1'b1,VM},
    '{1'b0,1'b1,1'b0,4'hF,8'h11,1'b0,Z ,1'b0,Z },
    '{1'b0,1'b0,1'b0,4'hF,8'h00,1'b0,Z ,1'b1,VM},
    '{1'b0,1'b1,1'b1,4'hF,8'h21,1'b0,Z ,1'b0,Z },
    '{1'b1,1'b0,1'b0,4'hF,8'h00,1'b0,Z ,1'b0,Z },
    '{1'b1,1'b0,1'b0,4'hF,8'h00,1'b0,E0,1'b0,Z },
    '{1'b1,1'b0,1'b0,4'hF,8'h00,1'b0,E1,1'b0,Z },
    '{1'b0,1'b0,1'b0,4'hF,8'h00,1'b0,E2,1'b0,Z },
    '{1'b0,1'b0,1'b0,4'hF,8'h00,1'b0,E3,1'b0,Z },
    '{1'b0,1'b1,1'b0,4'hF,8'h21,1'b1,Z ,1'b0,Z },
    '{1'b1,1'b0,1'b0,4'hF,8'h00,1'b0,Z ,1'b1,E0},
    '{1'b1,1'b0,1'b0,4'hF,8'h00,1'b0,Z ,1'b1,E3},
    '{1'b1,1'b0,1'b0,4'hF,8'h00,1'b0,Z ,1'b1,E2},
    '{1'b0,1'b0,1'b0,4'hF,8'h00,1'b0,Z ,1'b1,E1},
    '{1'b0,1'b0,1'b0,4'hF,8'h00,1'b0,Z ,1'b0,Z }
  };

  logic             clk;
  logic             rst_n;
  logic             clk_en;
  logic             adv_load;
  logic             wr_en;
  logic [LANES-1:0] byte_sel;
  logic             cs1_n, cs2, cs3_n;
  logic             burst_interleave;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    din;
  logic [DW-1:0]    dout;
  logic             dout_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pipelined_sram #(.AW(AW), .LANES(LANES), .LW(9)) i_pipelined_sram (
    .clk              (clk),
    .rst_n            (rst_n),
    .clk_en           (clk_en),
    .adv_load         (adv_load),
    .wr_en            (wr_en),
    .byte_sel         (byte_sel),
    .cs1_n            (cs1_n),
    .cs2              (cs2),
    .cs3_n            (cs3_n),
    .burst_interleave (burst_interleave),
    .addr             (addr),
    .din              (din),
    .dout             (dout),
    .dout_oe          (dout_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ce, input logic adv, input logic c1n, input logic c2,
                      input logic c3n, input logic wr, input logic [3:0] be,
                      input logic [7:0] a, input logic mode, input logic [DW-1:0] d);
    clk_en = ce; adv_load = adv; cs1_n = c1n; cs2 = c2; cs3_n = c3n;
    wr_en = wr; byte_sel = be; addr = a; burst_interleave = mode; din = d;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic nop(input logic [DW-1:0] d);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 8'h00, 1'b0, d);
  endtask

  task automatic ld(input logic wr, input logic [3:0] be, input logic [7:0] a,
                    input logic [DW-1:0] d);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, wr, be, a, 1'b0, d);
  endtask

  initial begin
    rst_n = 1'b0;
    clk_en = 1'b1; adv_load = 1'b0; wr_en = 1'b0; byte_sel = '0;
    cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; burst_interleave = 1'b0;
    addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    repeat (3) nop(Z);

    // R9: reset state
    chk("R9 oe after reset", {35'd0, dout_oe}, 36'd0);
    chk("R9 dout after reset", dout, Z);

    // table walk: R1 R3 R4 R6 R7 R8
    for (int i = 0; i < NROWS; i++) begin
      step(1'b1, TBL[i].adv, !TBL[i].sel, TBL[i].sel, !TBL[i].sel, TBL[i].wr,
           TBL[i].be, TBL[i].a, TBL[i].mode, TBL[i].d);
      chk($sformatf("R1/R6 row %0d oe", i), {35'd0, dout_oe}, {35'd0, TBL[i].eoe});
      if (TBL[i].eoe)
        chk($sformatf("R3/R4/R7/R8 row %0d data", i), dout, TBL[i].edo);
    end

    // R5: each single chip select in its inactive state deselects
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 8'h10, 1'b0, Z);
    nop(Z);
    chk("R5 cs1_n high deselects", {35'd0, dout_oe}, 36'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 8'h10, 1'b0, Z);
    nop(Z);
    chk("R5 cs2 low deselects", {35'd0, dout_oe}, 36'd0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 8'h10, 1'b0, Z);
    nop(Z);
    chk("R5 cs3_n high deselects", {35'd0, dout_oe}, 36'd0);

    // R5: deselected write leaves the stored word alone
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 8'h10, 1'b0, Z);
    nop(Z);
    nop(36'hFFFFFFFFF);
    ld(1'b0, 4'hF, 8'h10, Z);
    nop(Z);
    chk("R5 deselected write ignored", dout, VA);

    // R8: advancing after a deselected load gives no data
    nop(Z);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 8'h00, 1'b0, Z);
    nop(Z);
    chk("R8 dead burst idle", {35'd0, dout_oe}, 36'd0);

    // R2: stalled read
    ld(1'b0, 4'hF, 8'h12, Z);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 8'h00, 1'b0, Z);
    chk("R2 stall keeps oe low", {35'd0, dout_oe}, 36'd0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 8'h00, 1'b0, Z);
    chk("R2 stall keeps oe low again", {35'd0, dout_oe}, 36'd0);
    nop(Z);
    chk("R2 read after stall", dout, VC);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 8'h00, 1'b0, Z);
    chk("R2 data held in stall", dout, VC);
    chk("R2 oe held in stall", {35'd0, dout_oe}, 36'd1);

    // R2/R3: stalled edge does not count toward the write data slot
    ld(1'b1, 4'hF, 8'h30, Z);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 8'h00, 1'b0, 36'h111111111);
    nop(36'h222222222);
    nop(36'h9ABCDEF01);
    ld(1'b0, 4'hF, 8'h30, Z);
    nop(Z);
    chk("R2 write data after stall", dout, 36'h9ABCDEF01);

    finish_run();
  end

endmodule